// File: doc/BRIEF.md
# MSI vector capture controller

This block lives in the application register space next to a PCIe root port and turns inbound message-signalled interrupt writes into pending bits that software can see, enable and acknowledge. An endpoint's MSI memory write arrives on a dedicated strobe with its address and data. When the address is the doorbell, the low five data bits name one of 32 vectors. The vector is recorded as a pending bit in one of eight small status registers.

Vectors are spread across the registers in an interleaved way. Vector n goes to register n mod 8, at bit n div 8. Each register therefore holds four vectors that share one interrupt line.

Software works through a plain 32-bit register bus:
- It acknowledges pending bits with write-one-to-clear.
- It switches vectors on and off through separate set and clear addresses.
- After servicing a group, it writes an end-of-interrupt code so that a source that is still pending raises a fresh edge on that group's line.

Top module: `msi_capture_ctrl`

## Requirements
- R1: An MSI write whose address is 0x054 sets the pending bit of the vector given by data bits [4:0]. Data bits [31:5] are ignored. An MSI write to any other address changes nothing.
- R2: Vector n sets bit (n div 8) of status register (n mod 8). Status register k is read at 0x104 + 16·k, with the pending bits in [3:0] and bits [31:4] reading zero.
- R3: A bus write to status register k clears each pending bit whose written bit is 1. Bits written as 0 keep their value.
- R4: A bus write to 0x108 + 16·k enables the vectors of group k whose written bits [3:0] are 1. A write to 0x10C + 16·k disables those vectors. A read of either address returns the group's current 4-bit enable mask.
- R5: irq_o[k] is a register. After each clock edge it equals the OR of (status k AND enable k) as updated by that same edge.
- R6: A bus write of value v to 0x050, with 4 ≤ v ≤ 11, drives irq_o[v−4] low for the one cycle after that edge. The line is re-evaluated per R5 on the next edge. Any other value written to 0x050 has no effect.
- R7: If an MSI write and a clearing status write hit the same bit in the same cycle, the bit stays pending.
- R8: Reset clears all pending bits, all enables and all interrupt outputs.
- R9: Reads of 0x050, 0x054 and of any address outside the status and enable registers return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_valid | input | 1 | Inbound MSI write strobe |
| msi_addr | input | 12 | Register-space offset targeted by the MSI write |
| msi_data | input | 32 | MSI write data; low 5 bits carry the vector |
| bus_we | input | 1 | Register bus write enable |
| bus_addr | input | 12 | Register bus offset (read and write) |
| bus_wdata | input | 32 | Register bus write data |
| bus_rdata | output | 32 | Register bus read data, combinational from bus_addr |
| irq_o | output | 8 | One interrupt line per group |

## Verification
Directed cases cover several specific situations:
- A doorbell write with the upper data bits all set shows whether only bits [4:0] select the vector.
- An MSI aimed at a neighbouring offset shows whether the address filter works.
- A collision of MSI and clearing write on one bit shows whether the MSI takes priority.
- End-of-interrupt values just inside and just outside the 4..11 range show whether the one-cycle drop lands on the right group and only there.

Random traffic then mixes doorbell writes, stray MSIs, clears, enable changes and end-of-interrupt codes, sometimes in the same cycle. Every output line is compared each cycle against a bench model, and full register read-backs are made periodically. Any error in the interleaved vector-to-register mapping would move a bit to the wrong line or register address, and these comparisons would show it.

// File: rtl/msicap_pkg.sv
package msicap_pkg;
    localparam int DEF_NGRP       = 8;
    localparam int DEF_GBITS      = 4;
    localparam int DEF_AW         = 12;
    localparam int DEF_DW         = 32;
    localparam int DEF_DOORBELL   = 'h054;
    localparam int DEF_EOI_OFS    = 'h050;
    localparam int DEF_STAT_BASE  = 'h104;
    localparam int DEF_STRIDE     = 16;
    localparam int DEF_EOI_BIAS   = 4;

    // register kind within one group's window
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_STAT = 2'd1,
        ACC_ESET = 2'd2,
        ACC_ECLR = 2'd3
    } acc_e;
endpackage

// File: rtl/msicap_decode.sv
module msicap_decode #(
    parameter int NGRP      = msicap_pkg::DEF_NGRP,
    parameter int GBITS     = msicap_pkg::DEF_GBITS,
    parameter int AW        = msicap_pkg::DEF_AW,
    parameter int DW        = msicap_pkg::DEF_DW,
    parameter int DOORBELL  = msicap_pkg::DEF_DOORBELL,
    parameter int EOI_OFS   = msicap_pkg::DEF_EOI_OFS,
    parameter int STAT_BASE = msicap_pkg::DEF_STAT_BASE,
    parameter int STRIDE    = msicap_pkg::DEF_STRIDE,
    parameter int EOI_BIAS  = msicap_pkg::DEF_EOI_BIAS
) (
    input  logic                    msi_valid,
    input  logic [AW-1:0]           msi_addr,
    input  logic [DW-1:0]           msi_data,
    input  logic                    bus_we,
    input  logic [AW-1:0]           bus_addr,
    input  logic [DW-1:0]           bus_wdata,
    output logic [NGRP*GBITS-1:0]   vec_set,   // index = vector number
    output logic [NGRP-1:0]         w1c_we,
    output logic [NGRP-1:0]         eset_we,
    output logic [NGRP-1:0]         eclr_we,
    output logic [NGRP-1:0]         eoi_hit,
    output logic [GBITS-1:0]        wmask
);
    import msicap_pkg::*;

    localparam int NVEC  = NGRP * GBITS;
    localparam int VEC_W = $clog2(NVEC);
    localparam logic [AW-1:0] DB_A  = AW'(DOORBELL);
    localparam logic [AW-1:0] EOI_A = AW'(EOI_OFS);

    logic              msi_hit;
    logic [VEC_W-1:0]  vec;
    logic              eoi_wr;
    logic              eoi_in_range;
    logic [DW-1:0]     eoi_idx;

    assign msi_hit = msi_valid && (msi_addr == DB_A);
    assign vec     = msi_data[VEC_W-1:0];
    assign vec_set = msi_hit ? (NVEC'(1) << vec) : '0;
    assign wmask   = bus_wdata[GBITS-1:0];

    assign eoi_wr       = bus_we && (bus_addr == EOI_A);
    assign eoi_idx      = bus_wdata - DW'(EOI_BIAS);
    assign eoi_in_range = (bus_wdata >= DW'(EOI_BIAS)) &&
                          (bus_wdata <  DW'(EOI_BIAS + NGRP));

    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        localparam logic [AW-1:0] A_ST = AW'(STAT_BASE + STRIDE * k);
        localparam logic [AW-1:0] A_ES = AW'(STAT_BASE + STRIDE * k + 4);
        localparam logic [AW-1:0] A_EC = AW'(STAT_BASE + STRIDE * k + 8);
        acc_e kind;

        always_comb begin
            kind = ACC_NONE;
            if (bus_addr == A_ST) kind = ACC_STAT;
            if (bus_addr == A_ES) kind = ACC_ESET;
            if (bus_addr == A_EC) kind = ACC_ECLR;
        end

        assign w1c_we[k]  = bus_we && (kind == ACC_STAT);
        assign eset_we[k] = bus_we && (kind == ACC_ESET);
        assign eclr_we[k] = bus_we && (kind == ACC_ECLR);
        assign eoi_hit[k] = eoi_wr && eoi_in_range && (eoi_idx == DW'(k));
    end
endmodule

// File: rtl/msicap_group.sv
module msicap_group #(
    parameter int GBITS = msicap_pkg::DEF_GBITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GBITS-1:0] set_i,
    input  logic             w1c_we,
    input  logic             eset_we,
    input  logic             eclr_we,
    input  logic [GBITS-1:0] wmask,
    input  logic             eoi_i,
    output logic [GBITS-1:0] stat_o,
    output logic [GBITS-1:0] en_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [GBITS-1:0] stat;
        logic [GBITS-1:0] en;
        logic             irq;
    } grp_t;

    grp_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (w1c_we) st_d.stat = st_d.stat & ~wmask;
        // a new message is applied after the clear so it is never lost
        st_d.stat = st_d.stat | set_i;
        if (eset_we) st_d.en = st_d.en | wmask;
        if (eclr_we) st_d.en = st_d.en & ~wmask;
        st_d.irq = (|(st_d.stat & st_d.en)) && !eoi_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.stat;
    assign en_o   = st_q.en;
    assign irq_o  = st_q.irq;
endmodule

// File: rtl/msicap_rdmux.sv
module msicap_rdmux #(
    parameter int NGRP      = msicap_pkg::DEF_NGRP,
    parameter int GBITS     = msicap_pkg::DEF_GBITS,
    parameter int AW        = msicap_pkg::DEF_AW,
    parameter int DW        = msicap_pkg::DEF_DW,
    parameter int STAT_BASE = msicap_pkg::DEF_STAT_BASE,
    parameter int STRIDE    = msicap_pkg::DEF_STRIDE
) (
    input  logic [AW-1:0]          addr,
    input  logic [NGRP*GBITS-1:0]  stat_g,  // group-major
    input  logic [NGRP*GBITS-1:0]  en_g,    // group-major
    output logic [DW-1:0]          rdata
);
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NGRP; k++) begin
            if (addr == AW'(STAT_BASE + STRIDE * k))
                rdata[GBITS-1:0] = stat_g[k*GBITS +: GBITS];
            if (addr == AW'(STAT_BASE + STRIDE * k + 4) ||
                addr == AW'(STAT_BASE + STRIDE * k + 8))
                rdata[GBITS-1:0] = en_g[k*GBITS +: GBITS];
        end
    end
endmodule

// File: rtl/msi_capture_ctrl.sv
module msi_capture_ctrl #(
    parameter int NGRP      = msicap_pkg::DEF_NGRP,
    parameter int GBITS     = msicap_pkg::DEF_GBITS,
    parameter int AW        = msicap_pkg::DEF_AW,
    parameter int DW        = msicap_pkg::DEF_DW,
    parameter int DOORBELL  = msicap_pkg::DEF_DOORBELL,
    parameter int EOI_OFS   = msicap_pkg::DEF_EOI_OFS,
    parameter int STAT_BASE = msicap_pkg::DEF_STAT_BASE,
    parameter int STRIDE    = msicap_pkg::DEF_STRIDE,
    parameter int EOI_BIAS  = msicap_pkg::DEF_EOI_BIAS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            msi_valid,
    input  logic [AW-1:0]   msi_addr,
    input  logic [DW-1:0]   msi_data,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic [NGRP-1:0] irq_o
);
    localparam int NVEC = NGRP * GBITS;

    logic [NVEC-1:0]  vec_set;
    logic [NGRP-1:0]  w1c_we, eset_we, eclr_we, eoi_hit;
    logic [GBITS-1:0] wmask;
    logic [NVEC-1:0]  stat_g, en_g;    // group-major
    logic [NVEC-1:0]  stat_all, en_all; // vector-major: index = vector

    msicap_decode #(
        .NGRP(NGRP), .GBITS(GBITS), .AW(AW), .DW(DW),
        .DOORBELL(DOORBELL), .EOI_OFS(EOI_OFS), .STAT_BASE(STAT_BASE),
        .STRIDE(STRIDE), .EOI_BIAS(EOI_BIAS)
    ) u_dec (
        .msi_valid(msi_valid), .msi_addr(msi_addr), .msi_data(msi_data),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .vec_set(vec_set), .w1c_we(w1c_we), .eset_we(eset_we),
        .eclr_we(eclr_we), .eoi_hit(eoi_hit), .wmask(wmask)
    );

    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        logic [GBITS-1:0] set_k;
        for (genvar b = 0; b < GBITS; b++) begin : g_bit
            assign set_k[b]             = vec_set[b*NGRP + k];
            assign stat_all[b*NGRP + k] = stat_g[k*GBITS + b];
            assign en_all[b*NGRP + k]   = en_g[k*GBITS + b];
        end

        msicap_group #(.GBITS(GBITS)) u_grp (
            .clk(clk), .rst_n(rst_n), .set_i(set_k),
            .w1c_we(w1c_we[k]), .eset_we(eset_we[k]), .eclr_we(eclr_we[k]),
            .wmask(wmask), .eoi_i(eoi_hit[k]),
            .stat_o(stat_g[k*GBITS +: GBITS]),
            .en_o(en_g[k*GBITS +: GBITS]),
            .irq_o(irq_o[k])
        );
    end

    msicap_rdmux #(
        .NGRP(NGRP), .GBITS(GBITS), .AW(AW), .DW(DW),
        .STAT_BASE(STAT_BASE), .STRIDE(STRIDE)
    ) u_rd (
        .addr(bus_addr), .stat_g(stat_g), .en_g(en_g), .rdata(bus_rdata)
    );
endmodule

// File: rtl/msicap_checker.sv
module msicap_checker #(
    parameter int NGRP      = msicap_pkg::DEF_NGRP,
    parameter int GBITS     = msicap_pkg::DEF_GBITS,
    parameter int AW        = msicap_pkg::DEF_AW,
    parameter int DW        = msicap_pkg::DEF_DW,
    parameter int DOORBELL  = msicap_pkg::DEF_DOORBELL,
    parameter int EOI_OFS   = msicap_pkg::DEF_EOI_OFS,
    parameter int STAT_BASE = msicap_pkg::DEF_STAT_BASE,
    parameter int STRIDE    = msicap_pkg::DEF_STRIDE,
    parameter int EOI_BIAS  = msicap_pkg::DEF_EOI_BIAS
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  msi_valid,
    input logic [AW-1:0]         msi_addr,
    input logic [DW-1:0]         msi_data,
    input logic                  bus_we,
    input logic [AW-1:0]         bus_addr,
    input logic [DW-1:0]         bus_wdata,
    input logic [NGRP-1:0]       irq_o,
    input logic [NGRP*GBITS-1:0] stat_all,
    input logic [NGRP*GBITS-1:0] en_all
);
    localparam int NVEC  = NGRP * GBITS;
    localparam int VEC_W = $clog2(NVEC);

    for (genvar v = 0; v < NVEC; v++) begin : g_vec
        AST_MSI_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
            (msi_valid && msi_addr == AW'(DOORBELL) && msi_data[VEC_W-1:0] == VEC_W'(v))
            |=> stat_all[v]); // R1 R7
    end

    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        logic [GBITS-1:0] st_k, en_k;
        for (genvar b = 0; b < GBITS; b++) begin : g_b
            assign st_k[b] = stat_all[b*NGRP + k];
            assign en_k[b] = en_all[b*NGRP + k];
        end

        AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[k] |-> (|(st_k & en_k))); // R5

        AST_EOI_DROPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == AW'(EOI_OFS) && bus_wdata == DW'(EOI_BIAS + k))
            |=> !irq_o[k]); // R6

        AST_ENABLE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == AW'(STAT_BASE + STRIDE * k + 8))
            |=> ((en_k & $past(bus_wdata[GBITS-1:0])) == '0)); // R4
    end

    AST_PENDING_ONLY_FROM_MSI: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_all & ~$past(stat_all)) != '0) |-> $past(msi_valid)); // R1
endmodule

bind msi_capture_ctrl msicap_checker #(
    .NGRP(NGRP), .GBITS(GBITS), .AW(AW), .DW(DW),
    .DOORBELL(DOORBELL), .EOI_OFS(EOI_OFS), .STAT_BASE(STAT_BASE),
    .STRIDE(STRIDE), .EOI_BIAS(EOI_BIAS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_addr(msi_addr),
    .msi_data(msi_data), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .irq_o(irq_o), .stat_all(stat_all), .en_all(en_all)
);

// File: tb/tb_msi_capture_ctrl.sv
`timescale 1ns/1ps
module tb_msi_capture_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msi_valid = 1'b0;
    logic [11:0] msi_addr = '0;
    logic [31:0] msi_data = '0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  irq_o;

    int checks = 0;
    int errors = 0;

    bit [31:0] m_stat, m_en;   // index = vector number
    bit [7:0]  m_irq;

    msi_capture_ctrl dut (
        .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_addr(msi_addr),
        .msi_data(msi_data), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always #5 clk = ~clk;

    function automatic bit [3:0] grp(bit [31:0] v, int k);
        bit [3:0] g;
        for (int b = 0; b < 4; b++) g[b] = v[b*8 + k];
        return g;
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // advance one clock, update the model from the driven inputs, compare lines
    task automatic cycle(string tag);
        bit [7:0] eoi;
        int off, k, sub;
        @(posedge clk);
        eoi = '0;
        if (!rst_n) begin
            m_stat = '0; m_en = '0; m_irq = '0;
        end else begin
            if (bus_we) begin
                if (bus_addr == 12'h050 && bus_wdata >= 4 && bus_wdata < 12)
                    eoi[bus_wdata - 4] = 1'b1;
                off = int'(bus_addr) - 'h104;
                if (off >= 0 && off < 128) begin
                    k = off / 16; sub = off % 16;
                    for (int b = 0; b < 4; b++) if (bus_wdata[b]) begin
                        if (sub == 0) m_stat[b*8+k] = 1'b0;
                        if (sub == 4) m_en[b*8+k]   = 1'b1;
                        if (sub == 8) m_en[b*8+k]   = 1'b0;
                    end
                end
            end
            if (msi_valid && msi_addr == 12'h054) m_stat[msi_data[4:0]] = 1'b1;
            for (int g = 0; g < 8; g++)
                m_irq[g] = (|(grp(m_stat, g) & grp(m_en, g))) && !eoi[g];
        end
        @(negedge clk);
        bus_we = 1'b0; msi_valid = 1'b0;
        chk(tag, {24'h0, irq_o}, {24'h0, m_irq});
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d, string tag);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        cycle(tag);
    endtask

    task automatic msi(logic [11:0] a, logic [31:0] d, string tag);
        msi_valid = 1'b1; msi_addr = a; msi_data = d;
        cycle(tag);
    endtask

    task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic readback();
        for (int k = 0; k < 8; k++) begin
            rd(12'(32'h104 + 16*k), {28'h0, grp(m_stat, k)}, "R2 status readback");
            rd(12'(32'h108 + 16*k), {28'h0, grp(m_en, k)},   "R4 enable-set readback");
            rd(12'(32'h10C + 16*k), {28'h0, grp(m_en, k)},   "R4 enable-clear readback");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0417));
        @(negedge clk);
        cycle("R8 reset"); cycle("R8 reset");
        rst_n = 1'b1;
        chk("R8 irq after reset", {24'h0, irq_o}, 32'h0);
        readback();

        // R1/R2: upper data bits ignored, vector 9 -> group 1 bit 1
        msi(12'h054, 32'hFFFF_FFE9, "R1 doorbell");
        rd(12'h114, 32'h2, "R2 vector 9 in group 1 bit 1");
        // R1: wrong address ignored
        msi(12'h058, 32'h3, "R1 stray msi");
        rd(12'h134, 32'h0, "R1 stray msi ignored");
        // R4/R5
        wr(12'h118, 32'h2, "R5 enable group 1");
        chk("R5 line up", {31'h0, irq_o[1]}, 32'h1);
        rd(12'h118, 32'h2, "R4 set reads mask");
        rd(12'h11C, 32'h2, "R4 clear reads mask");
        // R6: EOI for group 1 (value 5)
        wr(12'h050, 32'h5, "R6 eoi");
        chk("R6 line dropped", {31'h0, irq_o[1]}, 32'h0);
        cycle("R6 re-evaluate");
        chk("R6 line back", {31'h0, irq_o[1]}, 32'h1);
        wr(12'h050, 32'hC, "R6 eoi out of range");
        chk("R6 value 12 no effect", {31'h0, irq_o[1]}, 32'h1);
        wr(12'h050, 32'h3, "R6 eoi out of range");
        chk("R6 value 3 no effect", {31'h0, irq_o[1]}, 32'h1);
        // R3
        wr(12'h114, 32'hFFFF_FFF1, "R3 w1c other bits");
        rd(12'h114, 32'h2, "R3 zero bit kept");
        wr(12'h114, 32'h2, "R3 w1c");
        rd(12'h114, 32'h0, "R3 bit cleared");
        chk("R3 line low", {31'h0, irq_o[1]}, 32'h0);
        // R7: vector 16 (group 0 bit 2) vs clear in same cycle
        msi(12'h054, 32'h10, "R7 prime");
        msi_valid = 1'b1; msi_addr = 12'h054; msi_data = 32'h10;
        bus_we = 1'b1; bus_addr = 12'h104; bus_wdata = 32'h4;
        cycle("R7 collision");
        rd(12'h104, 32'h4, "R7 msi wins");
        // R9
        rd(12'h050, 32'h0, "R9 eoi reads zero");
        rd(12'h054, 32'h0, "R9 doorbell reads zero");
        rd(12'h100, 32'h0, "R9 unmapped");
        rd(12'h110, 32'h0, "R9 unmapped gap");
        rd(12'h184, 32'h0, "R9 past last group");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            int op;
            op = int'($urandom % 8);
            if (op < 3) begin
                msi_valid = 1'b1; msi_data = $urandom;
                msi_addr = (op == 0) ? 12'(32'h050 + 4*($urandom % 3)) : 12'h054;
            end
            if (op >= 2) begin
                int k; k = int'($urandom % 8);
                bus_we = 1'b1;
                bus_wdata = {$urandom, 4'(0)} | 32'($urandom % 16);
                case (op)
                    2, 3: bus_addr = 12'(32'h104 + 16*k);
                    4, 5: bus_addr = 12'(32'h108 + 16*k);
                    6:    bus_addr = 12'(32'h10C + 16*k);
                    default: begin bus_addr = 12'h050; bus_wdata = $urandom % 16; end
                endcase
            end
            cycle("R5 random line");
            if (i % 100 == 99) readback();
        end

        // R8: reset in mid-operation
        rst_n = 1'b0;
        cycle("R8 reset again");
        rst_n = 1'b1;
        chk("R8 irq cleared", {24'h0, irq_o}, 32'h0);
        readback();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule